// File: doc/BRIEF.md
# Quaternary Signed-Digit to Integer Converter

This block takes a word of radix-4 signed digits and its signed carry-out and turns them into an ordinary two's-complement integer. The digit word usually comes from a carry-free adder. Each digit is a 3-bit two's-complement field with a legal range of -3 to +3. Each digit is sign-extended, weighted by its power of four, and summed. The carry-out is added at the weight just above the top digit.

The width of the result covers every legal word with its carry. It also covers every encoding the inputs can carry, including the illegal ones. For that reason an illegal word still yields its plain arithmetic value, and a separate flag marks it.

A parameter selects one of two modes. In the default mode a register stage loads the result when the input strobe is high, and a registered valid bit goes with it. In the other mode the block is purely combinational and the valid bit is passed straight through.

Top module: `qsd_to_int`

## Requirements
- R1: Digit i is the 3-bit two's-complement field `digits_i[3i+2:3i]` and contributes its value times 4^i to `value_o`.
- R2: `carry_i` is a 2-bit two's-complement value. The codes 2'b11, 2'b00 and 2'b01 mean -1, 0 and +1, and the carry contributes its value times 4^DIGITS.
- R3: `value_o` is signed and 2*DIGITS+3 bits wide. For any word with no illegal code its magnitude never exceeds 2*4^DIGITS-1.
- R4: `bad_o` is 1 whenever at least one digit field equals 3'b100.
- R5: `bad_o` is 1 whenever `carry_i` equals 2'b10. When no digit field is 3'b100 and the carry is not 2'b10, `bad_o` is 0.
- R6: Illegal codes still count arithmetically in `value_o`: a digit 3'b100 counts as -4 and the carry 2'b10 counts as -2.
- R7: With REGISTERED=1, a word presented with `in_valid` high appears on `value_o` and `bad_o` after the next rising clock edge, and `valid_o` is 1 for that cycle.
- R8: With REGISTERED=1, a clock edge with `in_valid` low leaves `value_o` and `bad_o` unchanged and drives `valid_o` to 0.
- R9: With REGISTERED=1, a synchronous active-high `rst` clears `value_o`, `bad_o` and `valid_o` to 0.
- R10: With REGISTERED=0, `value_o` and `bad_o` follow the inputs in the same cycle, and `valid_o` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| digits_i | input | 3*DIGITS | Packed signed digits, digit 0 in the low bits |
| carry_i | input | 2 | Signed carry-out of the digit word |
| value_o | output | 2*DIGITS+3 | Two's-complement result |
| bad_o | output | 1 | An illegal digit or carry code is present |
| valid_o | output | 1 | Result is valid |

## Verification
On every cycle, the assertions check the timing of the registered mode. They confirm that a strobe is followed by a high valid bit and that a quiet edge holds the result and the flag. They also confirm that an illegal carry code always raises the flag and that a flagged-clean result stays inside the legal magnitude bound. Only the bench's sweeps can show that each digit lands at the right weight and that the arithmetic value is exact. The sweeps cover every legal four-digit word with every legal carry, plus the illegal digit and carry codes, and every two-digit word in the combinational mode.

// File: rtl/qsd_to_int.sv
module qsd_to_int #(
  parameter int DIGITS     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [3*DIGITS-1:0]       digits_i,
  input  logic [1:0]                carry_i,
  output logic signed [2*DIGITS+2:0] value_o,
  output logic                      bad_o,
  output logic                      valid_o
);
  localparam int OUT_W = 2*DIGITS + 3;
  localparam int LIM   = 2*(4**DIGITS) - 1;

  logic signed [OUT_W-1:0] acc;
  logic                    bad;

  always_comb begin
    acc = {{(OUT_W-2){carry_i[1]}}, carry_i} << (2*DIGITS);
    bad = (carry_i == 2'b10);
    for (int i = 0; i < DIGITS; i++) begin
      acc = acc + ({{(OUT_W-3){digits_i[3*i+2]}}, digits_i[3*i +: 3]} << (2*i));
      bad = bad | (digits_i[3*i +: 3] == 3'b100);
    end
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          value_o <= '0;
          bad_o   <= 1'b0;
          valid_o <= 1'b0;
        end else begin
          valid_o <= in_valid;
          if (in_valid) begin
            value_o <= acc;
            bad_o   <= bad;
          end
        end
      end

      assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> valid_o);
      assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!valid_o && $stable(value_o) && $stable(bad_o)));
      assert_bad_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && carry_i == 2'b10) |=> bad_o);
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !bad_o) |-> (value_o <= LIM && value_o >= -LIM));
    end else begin : g_comb
      assign value_o = acc;
      assign bad_o   = bad;
      assign valid_o = in_valid;

      assert_bad_carry_comb_R5: assert property (@(posedge clk) disable iff (rst)
        (carry_i == 2'b10) |-> bad_o);
      assert_bad_digit_comb_R4: assert property (@(posedge clk) disable iff (rst)
        (digits_i[2:0] == 3'b100) |-> bad_o);
      assert_no_overflow_comb_R3: assert property (@(posedge clk) disable iff (rst)
        !bad_o |-> (value_o <= LIM && value_o >= -LIM));
    end
  endgenerate
endmodule

// File: tb/qsd_to_int_bench.sv
module qsd_to_int_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        in_valid = 1'b0;
  logic [11:0] digits = '0;
  logic [1:0]  carry = '0;
  logic signed [10:0] value;
  logic bad, valid;

  logic [5:0] digits2 = '0;
  logic [1:0] carry2 = '0;
  logic       in_valid2 = 1'b0;
  logic signed [6:0] value2;
  logic bad2, valid2;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  qsd_to_int #(.DIGITS(4), .REGISTERED(1'b1)) u_qsd_to_int (
    .clk(clk), .rst(rst), .in_valid(in_valid), .digits_i(digits), .carry_i(carry),
    .value_o(value), .bad_o(bad), .valid_o(valid));

  qsd_to_int #(.DIGITS(2), .REGISTERED(1'b0)) u_qsd_to_int_comb (
    .clk(clk), .rst(rst), .in_valid(in_valid2), .digits_i(digits2), .carry_i(carry2),
    .value_o(value2), .bad_o(bad2), .valid_o(valid2));

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int sx3(input logic [2:0] f);
    return f[2] ? int'(f) - 8 : int'(f);
  endfunction

  function automatic int sx2(input logic [1:0] f);
    return f[1] ? int'(f) - 4 : int'(f);
  endfunction

  function automatic int ref_val(input logic [11:0] d, input logic [1:0] c, input int n);
    int r = sx2(c) * (4 ** n);
    for (int i = 0; i < n; i++) r += sx3(d[3*i +: 3]) * (4 ** i);
    return r;
  endfunction

  function automatic int ref_bad(input logic [11:0] d, input logic [1:0] c, input int n);
    int b = (c == 2'b10);
    for (int i = 0; i < n; i++) if (d[3*i +: 3] == 3'b100) b = 1;
    return b;
  endfunction

  task automatic apply(input logic [11:0] d, input logic [1:0] c, input string tag);
    digits = d; carry = c; in_valid = 1'b1;
    @(posedge clk); #1;
    check(int'(value), ref_val(d, c, 4), {tag, " value R1 R2 R7"});
    check(int'(bad), ref_bad(d, c, 4), {tag, " flag R4 R5"});
    check(int'(valid), 1, {tag, " valid R7"});
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(int'(value), 0, "reset value R9");
    check(int'(bad), 0, "reset flag R9");
    check(int'(valid), 0, "reset valid R9");
    rst = 1'b0;

    for (int k = 0; k < 2401; k++) begin
      logic [11:0] d;
      int q = k;
      for (int i = 0; i < 4; i++) begin
        d[3*i +: 3] = 3'(q % 7 - 3);
        q = q / 7;
      end
      for (int c = -1; c <= 1; c++) apply(d, 2'(c), "sweep");
    end

    apply(12'b011_011_011_011, 2'b01, "max R3");
    check(int'(value), 511, "max value R3");
    apply(12'b101_101_101_101, 2'b11, "min R3");
    check(int'(value), -511, "min value R3");

    apply(12'b000_000_000_100, 2'b00, "digit0 illegal R4 R6");
    check(int'(value), -4, "digit0 -4 R6");
    apply(12'b100_000_000_000, 2'b00, "digit3 illegal R4 R6");
    check(int'(value), -256, "digit3 -256 R6");
    apply(12'b100_100_100_100, 2'b10, "all illegal R6");
    check(int'(value), -852, "all illegal value R6");
    apply(12'b000_001_000_000, 2'b10, "carry illegal R5 R6");
    check(int'(value), -496, "carry -2 R6");

    apply(12'b000_000_010_001, 2'b00, "pre-hold R8");
    digits = 12'b100_011_011_011; carry = 2'b10; in_valid = 1'b0;
    @(posedge clk); #1;
    check(int'(value), 9, "hold value R8");
    check(int'(bad), 0, "hold flag R8");
    check(int'(valid), 0, "hold valid R8");

    rst = 1'b1;
    @(posedge clk); #1;
    check(int'(value), 0, "mid reset value R9");
    check(int'(valid), 0, "mid reset valid R9");
    rst = 1'b0;

    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 4; c++) begin
        digits2 = 6'(k); carry2 = 2'(c); in_valid2 = k[0];
        #1;
        check(int'(value2), ref_val({6'b0, 6'(k)}, 2'(c), 2), "comb value R10 R1 R2 R6");
        check(int'(bad2), ref_bad({6'b0, 6'(k)}, 2'(c), 2), "comb flag R10 R4 R5");
        check(int'(valid2), k % 2, "comb valid R10");
        @(posedge clk); #1;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule